// File: doc/BRIEF.md
# Vector Operand Modifier Datapath

This block sits around the arithmetic core of a four-lane (x, y, z, w) 32-bit float shader unit. It handles operand preparation and result commit. Each issued instruction names up to three source registers in an internal temporary file. Every source has its own lane shuffle and its own sign modifiers. A small stand-in ALU forms a result. The result is then shaped for its destination and merged into the destination register lane by lane. The merge follows a static write mask and, optionally, per-lane condition-test bits.

There are two destination files. Temporaries can be read back as sources. Output registers are write-only and are observed through a separate read port. A pulse on `vtx_start` puts both files back into their per-vertex start state. Output registers inside a configurable colour window clamp every lane to the range [0.0, 1.0]. The datapath has one register stage. A write still pending in that stage is forwarded to reads issued in the same cycle, so dependent instructions can issue back to back.

Lanes are packed with lane i in bits [32i+31:32i]. Lane 0 is x and lane 3 is w.

Top module: `vecop_datapath`

## Requirements
- R1: Lane i of source s takes the component selected by `src_swz[8s+2i+1:8s+2i]`, with code 0=x, 1=y, 2=z, 3=w. Components may be replicated.
- R2: The sign modifiers change only bit 31 of each lane. The absolute flag (`src_abs[s]`) clears the sign first. The negate flag (`src_neg[s]`) then inverts it.
- R3: The three sources are read independently in the same cycle. One register may feed several sources, each with different shuffle and modifiers.
- R4: `iss_op` codes give the result as follows. 0 passes source A. 1 replicates lane x of the modified source A into all four lanes. 2 selects, per lane, source B where lane C has its sign set and a nonzero magnitude, and source A otherwise. 3 takes `imm_data` unmodified.
- R5: A lane of the destination is written only when its `wmask` bit is set and, with `cc_en`=1, its `cc_pass` bit is also set. All other lanes keep their previous value.
- R6: The full new destination content appears on `res_data` with `res_valid`=1 in the cycle after issue. The file updates at the following edge. An instruction issued in that cycle reads the new value. With no issue, `res_valid` is 0.
- R7: After reset or a `vtx_start` cycle, temporaries read (0,0,0,0) and output registers read w=0x3F800000 (1.0) with x, y and z zero. An instruction offered in a `vtx_start` cycle is ignored, and a write still pending in the register stage is dropped.
- R8: For output registers with index COL_BASE to COL_BASE+COL_NUM-1, each result lane is clamped before masking. A lane with bit 31 set becomes 0. A lane whose bits exceed 0x3F800000 becomes 0x3F800000 (this covers +inf and positive NaN). Other output registers are not clamped.
- R9: A destination index beyond its file is dropped, with `res_valid` staying 0. `out_rd_data` returns zero for an index beyond NOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vtx_start | input | 1 | Restore per-vertex start values of both files |
| iss_valid | input | 1 | Instruction offered this cycle |
| iss_op | input | 2 | Stand-in operation code |
| src_idx | input | 3*TIDX_W | Temporary index per source, source s at [s*TIDX_W +: TIDX_W] |
| src_swz | input | 24 | Lane shuffle per source, 8 bits each |
| src_neg | input | 3 | Negate flag per source |
| src_abs | input | 3 | Absolute flag per source |
| imm_data | input | 128 | Immediate vector for code 3 |
| dst_out | input | 1 | 1 writes the output file, 0 the temporary file |
| dst_idx | input | DST_W | Destination register index |
| wmask | input | 4 | Static lane write mask |
| cc_en | input | 1 | Enables condition gating of the write |
| cc_pass | input | 4 | Per-lane condition-test result |
| out_rd_idx | input | OIDX_W | Output register read index |
| out_rd_data | output | 128 | Output register content |
| res_valid | output | 1 | A write is committing this cycle |
| res_data | output | 128 | Full new content of the destination register |

## Verification
The bench builds the block with NTEMP=8, NOUT=6, COL_BASE=2 and COL_NUM=2. With only eight temporaries, random source and destination indices collide often. That makes back-to-back forwarding and same-register multi-source reads frequent without extra direction. Output indices 6 and 7 still fit the 3-bit index, so dropped writes and zero reads are reachable. The colour window sits in the middle of the output file, so clamped and unclamped neighbours are exercised side by side.

// File: rtl/vecop_pkg.sv
package vecop_pkg;

  localparam int LANES = 4;
  localparam int FW    = 32;
  localparam int VW    = LANES * FW;
  localparam int NSRC  = 3;
  localparam int SWZ_W = 2 * LANES;

  typedef enum logic [1:0] {
    OP_MOV = 2'd0,
    OP_SCL = 2'd1,
    OP_SEL = 2'd2,
    OP_LDI = 2'd3
  } op_e;

  localparam logic [FW-1:0] F_ONE    = 32'h3F80_0000;
  localparam logic [VW-1:0] OUT_INIT = {F_ONE, {(3*FW){1'b0}}};

  // Clamp one float lane into [0.0, 1.0] using bit patterns only.
  function automatic logic [FW-1:0] clamp01(input logic [FW-1:0] x);
    logic [FW-1:0] r;
    if (x[FW-1])        r = '0;
    else if (x > F_ONE) r = F_ONE;
    else                r = x;
    return r;
  endfunction

endpackage

// File: rtl/vecop_src_mod.sv
module vecop_src_mod
  import vecop_pkg::*;
(
  input  logic [VW-1:0]    vec_i,
  input  logic [SWZ_W-1:0] swz_i,
  input  logic             neg_i,
  input  logic             abs_i,
  output logic [VW-1:0]    vec_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0]    sel;
    logic [FW-1:0] picked;

    assign sel = swz_i[2*l +: 2];

    always_comb begin
      unique case (sel)
        2'd0: picked = vec_i[0*FW +: FW];
        2'd1: picked = vec_i[1*FW +: FW];
        2'd2: picked = vec_i[2*FW +: FW];
        default: picked = vec_i[3*FW +: FW];
      endcase
    end

    // sign: absolute first, then negate
    assign vec_o[l*FW +: FW] = {(picked[FW-1] & ~abs_i) ^ neg_i, picked[FW-2:0]};
  end

endmodule

// File: rtl/vecop_alu.sv
module vecop_alu
  import vecop_pkg::*;
(
  input  op_e           op_i,
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] b_i,
  input  logic [VW-1:0] c_i,
  input  logic [VW-1:0] imm_i,
  output logic [VW-1:0] res_o
);

  always_comb begin
    res_o = a_i;
    unique case (op_i)
      OP_MOV: res_o = a_i;
      OP_SCL: res_o = {LANES{a_i[FW-1:0]}};
      OP_SEL: begin
        for (int l = 0; l < LANES; l++) begin
          if (c_i[l*FW + FW-1] && (|c_i[l*FW +: FW-1]))
            res_o[l*FW +: FW] = b_i[l*FW +: FW];
          else
            res_o[l*FW +: FW] = a_i[l*FW +: FW];
        end
      end
      OP_LDI: res_o = imm_i;
    endcase
  end

endmodule

// File: rtl/vecop_regfile.sv
module vecop_regfile
  import vecop_pkg::*;
#(
  parameter int            DEPTH = 16,
  parameter int            IDX_W = $clog2(DEPTH),
  parameter int            NRD   = 1,
  parameter bit            FWD   = 1'b0,
  parameter logic [VW-1:0] INIT  = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic [NRD*IDX_W-1:0] rd_idx_i,
  output logic [NRD*VW-1:0]    rd_data_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [LANES-1:0]     wr_lane_i,
  input  logic [VW-1:0]        wr_data_i,
  output logic [VW-1:0]        wr_merged_o
);

  logic [VW-1:0] mem_q [DEPTH];
  logic [VW-1:0] mem_d [DEPTH];
  logic          wr_hit;
  logic          wr_commit;
  logic [VW-1:0] old_vec;

  // write-side merge of new lanes with the current content
  always_comb begin
    wr_hit    = int'(wr_idx_i) < DEPTH;
    old_vec   = wr_hit ? mem_q[wr_idx_i] : INIT;
    wr_commit = wr_en_i && wr_hit && !clr_i;
    for (int l = 0; l < LANES; l++) begin
      wr_merged_o[l*FW +: FW] = wr_lane_i[l] ? wr_data_i[l*FW +: FW]
                                             : old_vec[l*FW +: FW];
    end
  end

  // read ports; the variant with forwarding bypasses the pending write
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IDX_W-1:0] ridx;
    logic             fwd_hit;
    logic [VW-1:0]    rdata;

    assign ridx = rd_idx_i[r*IDX_W +: IDX_W];

    if (FWD) begin : g_fwd
      assign fwd_hit = wr_en_i && wr_hit && (ridx == wr_idx_i);
    end else begin : g_nofwd
      assign fwd_hit = 1'b0;
    end

    always_comb begin
      if (int'(ridx) >= DEPTH) rdata = '0;
      else if (fwd_hit)        rdata = wr_merged_o;
      else                     rdata = mem_q[ridx];
    end

    assign rd_data_o[r*VW +: VW] = rdata;
  end

  // next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_i)                                   mem_d[i] = INIT;
      else if (wr_commit && (int'(wr_idx_i) == i)) mem_d[i] = wr_merged_o;
      else                                         mem_d[i] = mem_q[i];
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (clr_i || wr_commit) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_MASKED_LANE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_hit && !clr_i && !wr_lane_i[l])
      |=> (mem_q[$past(wr_idx_i)][l*FW +: FW] == $past(old_vec[l*FW +: FW]))); // R5
  end

  AST_CLEAR_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((mem_q[0] == INIT) && (mem_q[DEPTH-1] == INIT))); // R7

endmodule

// File: rtl/vecop_datapath.sv
module vecop_datapath
  import vecop_pkg::*;
#(
  parameter int NTEMP    = 16,
  parameter int NOUT     = 16,
  parameter int COL_BASE = 1,
  parameter int COL_NUM  = 2,
  parameter int TIDX_W   = $clog2(NTEMP),
  parameter int OIDX_W   = $clog2(NOUT),
  parameter int DST_W    = (TIDX_W > OIDX_W) ? TIDX_W : OIDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vtx_start,
  input  logic                   iss_valid,
  input  logic [1:0]             iss_op,
  input  logic [NSRC*TIDX_W-1:0] src_idx,
  input  logic [NSRC*SWZ_W-1:0]  src_swz,
  input  logic [NSRC-1:0]        src_neg,
  input  logic [NSRC-1:0]        src_abs,
  input  logic [VW-1:0]          imm_data,
  input  logic                   dst_out,
  input  logic [DST_W-1:0]       dst_idx,
  input  logic [LANES-1:0]       wmask,
  input  logic                   cc_en,
  input  logic [LANES-1:0]       cc_pass,
  input  logic [OIDX_W-1:0]      out_rd_idx,
  output logic [VW-1:0]          out_rd_data,
  output logic                   res_valid,
  output logic [VW-1:0]          res_data
);

  // ---------------- reset synchroniser ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  // ---------------- stage 0: read, modify, compute ----------------
  logic [NSRC*VW-1:0] raw_flat;
  logic [NSRC*VW-1:0] mod_flat;
  logic [VW-1:0]      alu_res;
  logic [VW-1:0]      shaped;
  logic [LANES-1:0]   lane_en;
  logic               is_col;
  logic               dst_ok;
  logic               take;

  // stage 1 state
  logic               p_valid_q, p_valid_d;
  logic               p_out_q,   p_out_d;
  logic [DST_W-1:0]   p_idx_q,   p_idx_d;
  logic [LANES-1:0]   p_lane_q,  p_lane_d;
  logic [VW-1:0]      p_data_q,  p_data_d;

  logic [VW-1:0]      tmp_merged;
  logic [VW-1:0]      out_merged;

  vecop_regfile #(
    .DEPTH (NTEMP),
    .IDX_W (TIDX_W),
    .NRD   (NSRC),
    .FWD   (1'b1),
    .INIT  ('0)
  ) u_tmp (
    .clk         (clk),
    .rst_n       (rst_ns),
    .clr_i       (vtx_start),
    .rd_idx_i    (src_idx),
    .rd_data_o   (raw_flat),
    .wr_en_i     (p_valid_q && !p_out_q),
    .wr_idx_i    (p_idx_q[TIDX_W-1:0]),
    .wr_lane_i   (p_lane_q),
    .wr_data_i   (p_data_q),
    .wr_merged_o (tmp_merged)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    vecop_src_mod u_mod (
      .vec_i (raw_flat[s*VW +: VW]),
      .swz_i (src_swz[s*SWZ_W +: SWZ_W]),
      .neg_i (src_neg[s]),
      .abs_i (src_abs[s]),
      .vec_o (mod_flat[s*VW +: VW])
    );
  end

  vecop_alu u_alu (
    .op_i  (op_e'(iss_op)),
    .a_i   (mod_flat[0*VW +: VW]),
    .b_i   (mod_flat[1*VW +: VW]),
    .c_i   (mod_flat[2*VW +: VW]),
    .imm_i (imm_data),
    .res_o (alu_res)
  );

  always_comb begin
    is_col  = dst_out && (int'(dst_idx) >= COL_BASE) && (int'(dst_idx) < COL_BASE + COL_NUM);
    dst_ok  = dst_out ? (int'(dst_idx) < NOUT) : (int'(dst_idx) < NTEMP);
    take    = iss_valid && !vtx_start && dst_ok;
    lane_en = wmask & (cc_en ? cc_pass : {LANES{1'b1}});
    for (int l = 0; l < LANES; l++) begin
      shaped[l*FW +: FW] = is_col ? clamp01(alu_res[l*FW +: FW]) : alu_res[l*FW +: FW];
    end
  end

  // ---------------- pipeline register ----------------
  always_comb begin
    p_valid_d = take;
    p_out_d   = dst_out;
    p_idx_d   = dst_idx;
    p_lane_d  = lane_en;
    p_data_d  = shaped;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      p_valid_q <= 1'b0;
      p_out_q   <= 1'b0;
      p_idx_q   <= '0;
      p_lane_q  <= '0;
      p_data_q  <= '0;
    end else begin
      p_valid_q <= p_valid_d;
      if (take) begin
        p_out_q  <= p_out_d;
        p_idx_q  <= p_idx_d;
        p_lane_q <= p_lane_d;
        p_data_q <= p_data_d;
      end
    end
  end

  // ---------------- stage 1: commit ----------------
  vecop_regfile #(
    .DEPTH (NOUT),
    .IDX_W (OIDX_W),
    .NRD   (1),
    .FWD   (1'b0),
    .INIT  (OUT_INIT)
  ) u_out (
    .clk         (clk),
    .rst_n       (rst_ns),
    .clr_i       (vtx_start),
    .rd_idx_i    (out_rd_idx),
    .rd_data_o   (out_rd_data),
    .wr_en_i     (p_valid_q && p_out_q),
    .wr_idx_i    (p_idx_q[OIDX_W-1:0]),
    .wr_lane_i   (p_lane_q),
    .wr_data_i   (p_data_q),
    .wr_merged_o (out_merged)
  );

  assign res_valid = p_valid_q;
  assign res_data  = p_out_q ? out_merged : tmp_merged;

  // ---------------- checks ----------------
  AST_VTX_DROPS_ISSUE: assert property (@(posedge clk) disable iff (!rst_ns)
    vtx_start |=> !res_valid); // R7

  AST_BAD_DST_DROPPED: assert property (@(posedge clk) disable iff (!rst_ns)
    (iss_valid && !dst_ok) |=> !res_valid); // R9

  AST_SCALAR_REPLICATED: assert property (@(posedge clk) disable iff (!rst_ns)
    (take && (iss_op == 2'd1) && (wmask == 4'hF) && !cc_en)
    |=> ((res_data[0*FW +: FW] == res_data[1*FW +: FW]) &&
         (res_data[0*FW +: FW] == res_data[2*FW +: FW]) &&
         (res_data[0*FW +: FW] == res_data[3*FW +: FW]))); // R4

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_ABS_THEN_NEG: assert property (@(posedge clk) disable iff (!rst_ns)
      (take && (iss_op == 2'd0) && !dst_out && (wmask == 4'hF) && !cc_en && src_abs[0])
      |=> (res_data[l*FW + FW-1] == $past(src_neg[0]))); // R2

    AST_COLOUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ns)
      (res_valid && p_out_q && (int'(p_idx_q) >= COL_BASE) && (int'(p_idx_q) < COL_BASE + COL_NUM))
      |-> (!res_data[l*FW + FW-1] && (res_data[l*FW +: FW] <= F_ONE))); // R8
  end

endmodule

// File: tb/vecop_datapath_test.sv
module vecop_datapath_test;

  localparam int NT = 8;
  localparam int NO = 6;
  localparam int CB = 2;
  localparam int CN = 2;

  localparam logic [31:0] F1  = 32'h3F80_0000;
  localparam logic [31:0] F2  = 32'h4000_0000;
  localparam logic [31:0] F3  = 32'h4040_0000;
  localparam logic [31:0] F4  = 32'h4080_0000;
  localparam logic [31:0] H   = 32'h3F00_0000;
  localparam logic [31:0] NH  = 32'hBF00_0000;
  localparam logic [31:0] M2  = 32'hC000_0000;
  localparam logic [31:0] NZ  = 32'h8000_0000;
  localparam logic [31:0] QN  = 32'h7FC0_0000;
  localparam logic [23:0] IDN = 24'hE4E4E4;
  localparam logic [127:0] OINIT = {F1, 96'h0};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         vtx_start;
  logic         iss_valid;
  logic [1:0]   iss_op;
  logic [8:0]   src_idx;
  logic [23:0]  src_swz;
  logic [2:0]   src_neg;
  logic [2:0]   src_abs;
  logic [127:0] imm_data;
  logic         dst_out;
  logic [2:0]   dst_idx;
  logic [3:0]   wmask;
  logic         cc_en;
  logic [3:0]   cc_pass;
  logic [2:0]   out_rd_idx;
  logic [127:0] out_rd_data;
  logic         res_valid;
  logic [127:0] res_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [127:0] m_tmp [NT];
  logic [127:0] m_out [NO];

  always #4 clk = ~clk;

  vecop_datapath #(
    .NTEMP(NT), .NOUT(NO), .COL_BASE(CB), .COL_NUM(CN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vtx_start(vtx_start), .iss_valid(iss_valid),
    .iss_op(iss_op), .src_idx(src_idx), .src_swz(src_swz), .src_neg(src_neg),
    .src_abs(src_abs), .imm_data(imm_data), .dst_out(dst_out), .dst_idx(dst_idx),
    .wmask(wmask), .cc_en(cc_en), .cc_pass(cc_pass), .out_rd_idx(out_rd_idx),
    .out_rd_data(out_rd_data), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] f_mod(input logic [127:0] v, input logic [7:0] swz,
                                         input logic ab, input logic ng);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] x;
      x = v[32*swz[2*l +: 2] +: 32];
      r[32*l +: 32] = {(ab ? 1'b0 : x[31]) ^ ng, x[30:0]};
    end
    return r;
  endfunction

  function automatic logic [31:0] f_clamp(input logic [31:0] x);
    if (x[31]) return 32'h0;
    if (x > F1) return F1;
    return x;
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 10)
      0: return 32'h0;
      1: return NZ;
      2: return F1;
      3: return 32'hBF80_0000;
      4: return H;
      5: return NH;
      6: return F2;
      7: return QN;
      8: return 32'h3F7F_FFFF;
      default: return $urandom;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NT; i++) m_tmp[i] = '0;
    for (int i = 0; i < NO; i++) m_out[i] = OINIT;
  endtask

  // Issue one instruction at a falling edge; check the result one cycle later.
  task automatic run_instr(input logic [1:0] op, input logic [8:0] sidx, input logic [23:0] swz,
                           input logic [2:0] ng, input logic [2:0] ab, input logic [127:0] imm,
                           input logic dout, input logic [2:0] didx, input logic [3:0] wm,
                           input logic ce, input logic [3:0] cp, input string req);
    logic [127:0] a, b, c, r, old, nv;
    logic [127:0] s [3];
    logic [3:0]   en;
    logic         ok;
    iss_op = op; src_idx = sidx; src_swz = swz; src_neg = ng; src_abs = ab;
    imm_data = imm; dst_out = dout; dst_idx = didx; wmask = wm; cc_en = ce; cc_pass = cp;
    iss_valid = 1'b1;
    for (int k = 0; k < 3; k++)
      s[k] = f_mod(m_tmp[sidx[3*k +: 3]], swz[8*k +: 8], ab[k], ng[k]);
    a = s[0]; b = s[1]; c = s[2];
    case (op)
      2'd0: r = a;
      2'd1: r = {4{a[31:0]}};
      2'd2: for (int l = 0; l < 4; l++)
              r[32*l +: 32] = (c[32*l+31] && (c[32*l +: 31] != 0)) ? b[32*l +: 32] : a[32*l +: 32];
      default: r = imm;
    endcase
    if (dout && (int'(didx) >= CB) && (int'(didx) < CB + CN))
      for (int l = 0; l < 4; l++) r[32*l +: 32] = f_clamp(r[32*l +: 32]);
    en = wm & (ce ? cp : 4'hF);
    ok = dout ? (int'(didx) < NO) : 1'b1;
    old = '0;
    if (ok) old = dout ? m_out[didx] : m_tmp[didx];
    for (int l = 0; l < 4; l++) nv[32*l +: 32] = en[l] ? r[32*l +: 32] : old[32*l +: 32];
    if (ok) begin
      if (dout) m_out[didx] = nv;
      else      m_tmp[didx] = nv;
    end
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
    chk({req, " valid"}, {127'b0, res_valid}, {127'b0, ok});
    if (ok) chk({req, " data"}, res_data, nv);
  endtask

  task automatic idle();
    iss_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input logic [2:0] idx, input string req);
    out_rd_idx = idx;
    #1;
    chk(req, out_rd_data, (int'(idx) < NO) ? m_out[idx] : 128'h0);
  endtask

  task automatic do_vtx(input string req);
    vtx_start = 1'b1;
    iss_valid = 1'b1;
    iss_op = 2'd3; imm_data = {4{F3}}; dst_out = 1'b0; dst_idx = 3'd1; wmask = 4'hF; cc_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    vtx_start = 1'b0;
    iss_valid = 1'b0;
    model_reset();
    chk({req, " issue ignored"}, {127'b0, res_valid}, 128'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; vtx_start = 1'b0; iss_valid = 1'b0; iss_op = '0; src_idx = '0;
    src_swz = IDN; src_neg = '0; src_abs = '0; imm_data = '0; dst_out = 1'b0;
    dst_idx = '0; wmask = '0; cc_en = 1'b0; cc_pass = '0; out_rd_idx = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 reset state
    chk("R7 reset valid", {127'b0, res_valid}, 128'h0);
    for (int i = 0; i < 8; i++) chk_out(3'(i), "R7 reset out / R9 range");
    run_instr(2'd0, 9'o765, IDN, 3'b0, 3'b0, '0, 1'b0, 3'd6, 4'hF, 1'b0, 4'h0, "R7 reset temp");

    // R4 load, R1 shuffle
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {F4, F3, F2, F1}, 1'b0, 3'd0, 4'hF, 1'b0, 4'h0, "R4 load");
    run_instr(2'd0, 9'o0, 24'hE4E41B, 3'b0, 3'b0, '0, 1'b0, 3'd1, 4'hF, 1'b0, 4'h0, "R1 reverse");
    run_instr(2'd0, 9'o0, 24'hE4E4A5, 3'b0, 3'b0, '0, 1'b0, 3'd7, 4'hF, 1'b0, 4'h0, "R1 replicate");

    // R2 sign modifiers
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {M2, NZ, NH, H}, 1'b0, 3'd2, 4'hF, 1'b0, 4'h0, "R4 load signed");
    run_instr(2'd0, 9'o2, IDN, 3'b000, 3'b001, '0, 1'b0, 3'd3, 4'hF, 1'b0, 4'h0, "R2 abs");
    run_instr(2'd0, 9'o2, IDN, 3'b001, 3'b000, '0, 1'b0, 3'd3, 4'hF, 1'b0, 4'h0, "R2 neg");
    run_instr(2'd0, 9'o2, IDN, 3'b001, 3'b001, '0, 1'b0, 3'd3, 4'hF, 1'b0, 4'h0, "R2 abs then neg");

    // R3 same register on three sources, different modifiers; R4 select
    run_instr(2'd2, 9'o222, 24'hE400E4, 3'b001, 3'b010, '0, 1'b0, 3'd4, 4'hF, 1'b0, 4'h0, "R3 R4 select");
    run_instr(2'd1, 9'o0, 24'hE4E4FF, 3'b0, 3'b0, '0, 1'b0, 3'd5, 4'hF, 1'b0, 4'h0, "R4 scalar");

    // R5 masks
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {4{F2}}, 1'b0, 3'd4, 4'b0101, 1'b0, 4'h0, "R5 static mask");
    run_instr(2'd0, 9'o1, IDN, 3'b0, 3'b0, '0, 1'b0, 3'd4, 4'hF, 1'b1, 4'b1010, "R5 condition mask");
    run_instr(2'd0, 9'o1, IDN, 3'b0, 3'b0, '0, 1'b0, 3'd4, 4'b0110, 1'b1, 4'b0011, "R5 both masks");
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {4{F4}}, 1'b0, 3'd4, 4'h0, 1'b0, 4'h0, "R5 empty mask");

    // R6 back-to-back forwarding, then idle
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {H, F1, H, F3}, 1'b0, 3'd5, 4'hF, 1'b0, 4'h0, "R6 producer");
    run_instr(2'd0, 9'o5, 24'hE4E41B, 3'b0, 3'b0, '0, 1'b0, 3'd6, 4'hF, 1'b0, 4'h0, "R6 forwarded");
    run_instr(2'd1, 9'o6, IDN, 3'b001, 3'b0, '0, 1'b0, 3'd6, 4'hF, 1'b0, 4'h0, "R6 self chain");
    idle();
    chk("R6 idle valid", {127'b0, res_valid}, 128'h0);

    // R8 colour clamp
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {QN, F2, NH, H}, 1'b1, 3'd2, 4'hF, 1'b0, 4'h0, "R8 clamp");
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {32'h7F80_0000, F1, 32'h3F7F_FFFF, NZ}, 1'b1, 3'd3, 4'hF, 1'b0, 4'h0, "R8 edges");
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {M2, F2, NH, F4}, 1'b1, 3'd1, 4'hF, 1'b0, 4'h0, "R8 no clamp outside");
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {4{F3}}, 1'b1, 3'd2, 4'b1000, 1'b0, 4'h0, "R8 R5 masked clamp");
    // R9 dropped destination
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {4{F2}}, 1'b1, 3'd7, 4'hF, 1'b0, 4'h0, "R9 bad dst");
    idle();
    for (int i = 0; i < 8; i++) chk_out(3'(i), "R8 R9 out file");

    // R7 vertex restart drops pending write and ignores issue
    run_instr(2'd3, 9'o0, IDN, 3'b0, 3'b0, {4{F4}}, 1'b0, 3'd2, 4'hF, 1'b0, 4'h0, "R7 pending");
    do_vtx("R7 restart");
    for (int i = 0; i < 8; i++) chk_out(3'(i), "R7 out init");
    run_instr(2'd2, 9'o212, 24'h1BE4A5, 3'b101, 3'b010, '0, 1'b0, 3'd0, 4'hF, 1'b0, 4'h0, "R7 temp zero");

    // random phase
    for (int n = 0; n < 800; n++) begin
      logic [127:0] imm;
      for (int l = 0; l < 4; l++) imm[32*l +: 32] = pick();
      run_instr(2'($urandom), 9'($urandom), 24'($urandom), 3'($urandom), 3'($urandom), imm,
                ($urandom % 4) == 0, 3'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                "R1 R2 R3 R4 R5 R6 R8 R9 random");
      if ((n % 25) == 24) begin
        idle();
        for (int i = 0; i < 8; i++) chk_out(3'(i), "R5 R8 random out file");
      end
      if ((n % 97) == 96) do_vtx("R7 random restart");
    end

    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule